// File: doc/BRIEF.md
# Low-Power-Idle Interval Monitor

This block watches a link that saves power by going silent between short bursts of signalling. It takes a digital signal-detect input and a decoded line code (idle, sleep code groups, or frame data). From these it measures four intervals in clock cycles:

- **sleep** — how long sleep code groups are sent before the line goes silent;
- **quiet** — how long the line stays silent;
- **refresh** — each burst of sleep code groups between two silent spells;
- **wake** — the stretch of idle signalling between the last silent spell and the first frame.

Each finished interval is compared with its own conformance window. The block gives a one-cycle pass or fail verdict, keeps the last measured length of each kind, and counts failures per kind.

A quiet or refresh interval that frame data cuts short is not judged. Nothing is reported for it, and the monitor waits for a fresh sleep phase. The same holds for a sleep phase abandoned before silence and for a wake phase that loses signal before data arrives.

The window limits are parameters given in cycles. The defaults assume a 125 MHz clock:

| Interval | Pass condition (cycles) |
|---|---|
| sleep | strictly between 25000 and 27500 |
| refresh | strictly between 25000 and 27500 |
| quiet | strictly between 2500000 and 2750000 |
| wake | more than 3125 |

The block has no data stream, so it has no handshake. All pins are plain level or pulse signals, sampled on every clock.

Top module: `lpi_interval_monitor`

## Requirements
- R1: After reset all four last-length outputs, both verdict vectors and all four violation counters are zero.
- R2: Line code 2'b01 means sleep code groups. While the monitor is waiting in its active state, the first cycle with sig_det high and line code 2'b01 starts a sleep interval. The interval length is the number of cycles with sig_det high counted from that cycle onward. The first cycle with sig_det low closes it: ts_len takes the length and verdict index 0 pulses in the following cycle.
- R3: A quiet interval starts on the cycle sig_det is first low after a sleep or refresh interval. Its length is the count of low cycles. The first cycle with sig_det high closes it, giving tq_len and verdict index 1.
- R4: If line code is 2'b01 on that closing cycle, a refresh interval starts there and counts cycles with sig_det high. The next sig_det-low cycle closes it, giving tr_len and verdict index 2, and starts a new quiet interval.
- R5: If line code is idle (2'b00, with 2'b11 treated the same) on the quiet closing cycle, a wake interval starts there. A refresh that turns to idle before sig_det falls becomes a wake interval and keeps its count. The first data cycle (2'b10) closes the wake interval, giving tw_len and verdict index 3.
- R6: Sleep, quiet and refresh pass only when the length is strictly greater than the low limit and strictly less than the high limit. Wake passes only when the length is strictly greater than its minimum. Each closed interval raises exactly one of iv_pass or iv_fail at its index, for one cycle.
- R7: Data (2'b10) seen during a quiet or refresh interval truncates it. This includes data on the same cycle as the closing sig_det edge. A truncated interval produces no verdict and changes no length output or counter, and the monitor returns to waiting for a new sleep phase.
- R8: A sleep interval whose line code leaves 2'b01 before sig_det falls is dropped without a verdict.
- R9: Interval lengths saturate at 2^CNT_W-1 instead of wrapping, and are judged at that value.
- R10: Each interval kind has its own violation counter. It increments in the cycle after that kind's fail pulse and saturates at 2^VIO_W-1.
- R11: viol_clr synchronously clears all four violation counters and takes priority over a coincident increment.
- R12: A wake interval during which sig_det falls before data is dropped without a verdict.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sig_det | input | 1 | Digital signal-detect indication |
| line_code | input | 2 | Decoded line state: 00 idle, 01 sleep, 10 data, 11 idle |
| viol_clr | input | 1 | Synchronous clear of all violation counters |
| ts_len | output | CNT_W | Last judged sleep length |
| tq_len | output | CNT_W | Last judged quiet length |
| tr_len | output | CNT_W | Last judged refresh length |
| tw_len | output | CNT_W | Last judged wake length |
| iv_pass | output | 4 | Pass pulses, index 0 sleep, 1 quiet, 2 refresh, 3 wake |
| iv_fail | output | 4 | Fail pulses, same indexing |
| ts_viol | output | VIO_W | Sleep violation count |
| tq_viol | output | VIO_W | Quiet violation count |
| tr_viol | output | VIO_W | Refresh violation count |
| tw_viol | output | VIO_W | Wake violation count |

## Verification
The assertions take for granted that sig_det and line_code are synchronous to clk, carry known values after reset, and change only between clock edges. They also assume that signal drops during wake and data during quiet or refresh are legal stimulus rather than protocol errors.

The bench drives every input on the falling edge, using only the four line codes. Interval lengths are drawn with a fixed seed from a band a few cycles either side of each window, so both verdicts occur. Directed episodes place lengths exactly on every limit, truncate each interval kind, and saturate both the length and the violation counters.

// File: rtl/lpi_mon_pkg.sv
package lpi_mon_pkg;
  typedef enum logic [1:0] {
    LC_IDLE  = 2'b00,
    LC_SLEEP = 2'b01,
    LC_DATA  = 2'b10,
    LC_RSVD  = 2'b11
  } line_code_e;

  typedef enum logic [2:0] {
    ST_ACTIVE,
    ST_SLEEP,
    ST_QUIET,
    ST_REFRESH,
    ST_WAKE
  } mon_state_e;

  localparam int IV_SLEEP   = 0;
  localparam int IV_QUIET   = 1;
  localparam int IV_REFRESH = 2;
  localparam int IV_WAKE    = 3;
  localparam int IV_NUM     = 4;
endpackage

// File: rtl/lpi_sat_counter.sv
module lpi_sat_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] value
);
  localparam logic [W-1:0] TOP = '1;

  always_ff @(posedge clk) begin
    if (!rst_n || clr)
      value <= '0;
    else if (inc && value != TOP)
      value <= value + 1'b1;
  end

  AST_VIOL_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && value == TOP) |=> value == TOP); // R10
  AST_CLR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> value == '0); // R11
endmodule

// File: rtl/lpi_interval_fsm.sv
module lpi_interval_fsm
  import lpi_mon_pkg::*;
#(
  parameter int CNT_W = 22
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sig_det,
  input  logic [1:0]           line_code,
  output logic [IV_NUM-1:0]    close_fire,
  output logic [CNT_W-1:0]     close_len
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  mon_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d, cnt_inc;
  logic             is_sleep, is_data;

  assign is_sleep  = (line_code == LC_SLEEP);
  assign is_data   = (line_code == LC_DATA);
  assign cnt_inc   = (cnt_q == CNT_MAX) ? cnt_q : cnt_q + 1'b1;
  assign close_len = cnt_q;

  always_comb begin
    state_d    = state_q;
    cnt_d      = cnt_q;
    close_fire = '0;
    unique case (state_q)
      ST_ACTIVE: begin
        if (sig_det && is_sleep) begin
          state_d = ST_SLEEP;
          cnt_d   = CNT_ONE;
        end
      end
      ST_SLEEP: begin
        if (!sig_det) begin
          close_fire[IV_SLEEP] = 1'b1;
          state_d = ST_QUIET;
          cnt_d   = CNT_ONE;
        end else if (is_sleep) begin
          cnt_d = cnt_inc;
        end else begin
          state_d = ST_ACTIVE;
        end
      end
      ST_QUIET: begin
        if (is_data) begin
          state_d = ST_ACTIVE;
        end else if (sig_det) begin
          close_fire[IV_QUIET] = 1'b1;
          state_d = is_sleep ? ST_REFRESH : ST_WAKE;
          cnt_d   = CNT_ONE;
        end else begin
          cnt_d = cnt_inc;
        end
      end
      ST_REFRESH: begin
        if (is_data) begin
          state_d = ST_ACTIVE;
        end else if (!sig_det) begin
          close_fire[IV_REFRESH] = 1'b1;
          state_d = ST_QUIET;
          cnt_d   = CNT_ONE;
        end else begin
          if (!is_sleep) state_d = ST_WAKE;
          cnt_d = cnt_inc;
        end
      end
      ST_WAKE: begin
        if (!sig_det) begin
          state_d = ST_ACTIVE;
        end else if (is_data) begin
          close_fire[IV_WAKE] = 1'b1;
          state_d = ST_ACTIVE;
        end else begin
          cnt_d = cnt_inc;
        end
      end
      default: state_d = ST_ACTIVE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_ACTIVE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  AST_QUIET_TRUNC: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_QUIET && is_data) |=> state_q == ST_ACTIVE); // R7
  AST_REFRESH_TRUNC: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_REFRESH && is_data) |=> state_q == ST_ACTIVE); // R7
  AST_LEN_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == CNT_MAX && state_d == state_q) |=> cnt_q == CNT_MAX); // R9
  AST_WAKE_LOSS: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WAKE && !sig_det) |-> close_fire == '0); // R12
endmodule

// File: rtl/lpi_window_judge.sv
module lpi_window_judge #(
  parameter int CNT_W  = 22,
  parameter int VIO_W  = 16,
  parameter int LO     = 0,
  parameter int HI     = 1,
  parameter bit USE_HI = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fire,
  input  logic [CNT_W-1:0] len,
  input  logic             viol_clr,
  output logic [CNT_W-1:0] last_len,
  output logic             pass_p,
  output logic             fail_p,
  output logic [VIO_W-1:0] viol
);
  localparam logic [CNT_W-1:0] LO_C    = CNT_W'(LO);
  localparam logic [CNT_W-1:0] HI_C    = CNT_W'(HI);
  localparam logic [VIO_W-1:0] VIO_TOP = '1;

  logic in_win;
  assign in_win = (len > LO_C) && (!USE_HI || len < HI_C);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      last_len <= '0;
      pass_p   <= 1'b0;
      fail_p   <= 1'b0;
    end else begin
      if (fire) last_len <= len;
      pass_p <= fire && in_win;
      fail_p <= fire && !in_win;
    end
  end

  lpi_sat_counter #(.W(VIO_W)) u_viol (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (viol_clr),
    .inc   (fail_p),
    .value (viol)
  );

  AST_PASS_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    pass_p |-> (last_len > LO_C && (!USE_HI || last_len < HI_C))); // R6
  AST_VERDICT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (pass_p || fail_p) |=> !(pass_p || fail_p)); // R6
  AST_FAIL_COUNTED: assert property (@(posedge clk) disable iff (!rst_n)
    (fail_p && !viol_clr && viol != VIO_TOP) |=> viol == VIO_W'($past(viol) + 1'b1)); // R10
endmodule

// File: rtl/lpi_interval_monitor.sv
module lpi_interval_monitor
  import lpi_mon_pkg::*;
#(
  parameter int CNT_W  = 22,
  parameter int VIO_W  = 16,
  parameter int TS_LO  = 25000,
  parameter int TS_HI  = 27500,
  parameter int TQ_LO  = 2500000,
  parameter int TQ_HI  = 2750000,
  parameter int TR_LO  = 25000,
  parameter int TR_HI  = 27500,
  parameter int TW_MIN = 3125
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sig_det,
  input  logic [1:0]        line_code,
  input  logic              viol_clr,
  output logic [CNT_W-1:0]  ts_len,
  output logic [CNT_W-1:0]  tq_len,
  output logic [CNT_W-1:0]  tr_len,
  output logic [CNT_W-1:0]  tw_len,
  output logic [3:0]        iv_pass,
  output logic [3:0]        iv_fail,
  output logic [VIO_W-1:0]  ts_viol,
  output logic [VIO_W-1:0]  tq_viol,
  output logic [VIO_W-1:0]  tr_viol,
  output logic [VIO_W-1:0]  tw_viol
);
  logic [IV_NUM-1:0] close_fire;
  logic [CNT_W-1:0]  close_len;
  logic [CNT_W-1:0]  last_arr [IV_NUM];
  logic [VIO_W-1:0]  viol_arr [IV_NUM];

  lpi_interval_fsm #(.CNT_W(CNT_W)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .sig_det    (sig_det),
    .line_code  (line_code),
    .close_fire (close_fire),
    .close_len  (close_len)
  );

  for (genvar i = 0; i < IV_NUM; i++) begin : g_judge
    localparam int LO_I = (i == IV_SLEEP) ? TS_LO :
                          (i == IV_QUIET) ? TQ_LO :
                          (i == IV_REFRESH) ? TR_LO : TW_MIN;
    localparam int HI_I = (i == IV_SLEEP) ? TS_HI :
                          (i == IV_QUIET) ? TQ_HI :
                          (i == IV_REFRESH) ? TR_HI : 0;
    localparam bit USE_HI_I = (i != IV_WAKE);

    lpi_window_judge #(
      .CNT_W  (CNT_W),
      .VIO_W  (VIO_W),
      .LO     (LO_I),
      .HI     (HI_I),
      .USE_HI (USE_HI_I)
    ) u_judge (
      .clk      (clk),
      .rst_n    (rst_n),
      .fire     (close_fire[i]),
      .len      (close_len),
      .viol_clr (viol_clr),
      .last_len (last_arr[i]),
      .pass_p   (iv_pass[i]),
      .fail_p   (iv_fail[i]),
      .viol     (viol_arr[i])
    );
  end

  assign ts_len  = last_arr[IV_SLEEP];
  assign tq_len  = last_arr[IV_QUIET];
  assign tr_len  = last_arr[IV_REFRESH];
  assign tw_len  = last_arr[IV_WAKE];
  assign ts_viol = viol_arr[IV_SLEEP];
  assign tq_viol = viol_arr[IV_QUIET];
  assign tr_viol = viol_arr[IV_REFRESH];
  assign tw_viol = viol_arr[IV_WAKE];

  AST_ONE_VERDICT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(iv_pass | iv_fail)); // R6
  AST_NO_DOUBLE_VERDICT: assert property (@(posedge clk) disable iff (!rst_n)
    (iv_pass & iv_fail) == 4'b0000); // R6
endmodule

// File: tb/tb_lpi_interval_monitor.sv
module tb_lpi_interval_monitor;
  localparam int CW = 10, VW = 4;
  localparam int TS_LO = 20, TS_HI = 30, TQ_LO = 60, TQ_HI = 80;
  localparam int TR_LO = 20, TR_HI = 30, TW_MIN = 15;
  localparam int LEN_TOP = (1 << CW) - 1, VIO_TOP = (1 << VW) - 1;
  localparam logic [1:0] C_IDLE = 2'b00, C_SLP = 2'b01, C_DAT = 2'b10;

  logic clk = 1'b0, rst_n = 1'b0, sig_det = 1'b1, viol_clr = 1'b0;
  logic [1:0] line_code = C_IDLE;
  logic [CW-1:0] ts_len, tq_len, tr_len, tw_len;
  logic [3:0] iv_pass, iv_fail;
  logic [VW-1:0] ts_viol, tq_viol, tr_viol, tw_viol;

  int checks = 0, errors = 0;
  int obs_kind [256], obs_pass [256], obs_len [256];
  int exp_kind [256], exp_pass [256], exp_len [256];
  int obs_n = 0, exp_n = 0, chk_n = 0;
  int exp_viol [4] = '{0, 0, 0, 0};
  bit clr_hold = 1'b0;

  lpi_interval_monitor #(
    .CNT_W(CW), .VIO_W(VW), .TS_LO(TS_LO), .TS_HI(TS_HI), .TQ_LO(TQ_LO),
    .TQ_HI(TQ_HI), .TR_LO(TR_LO), .TR_HI(TR_HI), .TW_MIN(TW_MIN)
  ) dut (
    .clk(clk), .rst_n(rst_n), .sig_det(sig_det), .line_code(line_code),
    .viol_clr(viol_clr), .ts_len(ts_len), .tq_len(tq_len), .tr_len(tr_len),
    .tw_len(tw_len), .iv_pass(iv_pass), .iv_fail(iv_fail), .ts_viol(ts_viol),
    .tq_viol(tq_viol), .tr_viol(tr_viol), .tw_viol(tw_viol)
  );

  always #5 clk = ~clk;

  function automatic int len_out(int k);
    case (k)
      0: return int'(ts_len);
      1: return int'(tq_len);
      2: return int'(tr_len);
      default: return int'(tw_len);
    endcase
  endfunction

  function automatic int viol_out(int k);
    case (k)
      0: return int'(ts_viol);
      1: return int'(tq_viol);
      2: return int'(tr_viol);
      default: return int'(tw_viol);
    endcase
  endfunction

  function automatic bit win_ok(int k, int len);
    case (k)
      0: return len > TS_LO && len < TS_HI;
      1: return len > TQ_LO && len < TQ_HI;
      2: return len > TR_LO && len < TR_HI;
      default: return len > TW_MIN;
    endcase
  endfunction

  function automatic int rl(int lo, int hi);
    int v;
    v = lo - 3 + int'($urandom % 32'(hi - lo + 7));
    return (v < 1) ? 1 : v;
  endfunction

  // event recorder, sampled on the falling edge
  always @(negedge clk) begin
    if (rst_n) begin
      for (int k = 0; k < 4; k++) begin
        if (iv_pass[k] || iv_fail[k]) begin
          if (obs_n < 256) begin
            obs_kind[obs_n] = k;
            obs_pass[obs_n] = int'(iv_pass[k]);
            obs_len[obs_n]  = len_out(k);
          end
          obs_n++;
        end
      end
    end
  end

  task automatic check(bit c, string req, string what, int act, int exp);
    checks++;
    if (!c) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic drive(bit sd, logic [1:0] lc, int n);
    @(negedge clk);
    sig_det   = sd;
    line_code = lc;
    repeat (n) @(posedge clk);
  endtask

  task automatic expect_iv(int k, int len);
    int l;
    bit ok;
    l = (len > LEN_TOP) ? LEN_TOP : len;
    ok = win_ok(k, l);
    if (exp_n < 256) begin
      exp_kind[exp_n] = k;
      exp_pass[exp_n] = int'(ok);
      exp_len[exp_n]  = l;
    end
    exp_n++;
    if (!ok && !clr_hold && exp_viol[k] < VIO_TOP) exp_viol[k]++;
  endtask

  task automatic compare_events(string req);
    check(obs_n == exp_n, req, "verdict count", obs_n, exp_n);
    if (obs_n == exp_n) begin
      for (int i = chk_n; i < exp_n && i < 256; i++) begin
        check(obs_kind[i] == exp_kind[i], req, "verdict kind", obs_kind[i], exp_kind[i]);
        check(obs_pass[i] == exp_pass[i], req, "verdict pass", obs_pass[i], exp_pass[i]);
        check(obs_len[i] == exp_len[i], req, "interval length", obs_len[i], exp_len[i]);
      end
    end
    obs_n = exp_n;
    chk_n = exp_n;
  endtask

  task automatic check_viol(string req);
    for (int k = 0; k < 4; k++)
      check(viol_out(k) == exp_viol[k], req, "violation count", viol_out(k), exp_viol[k]);
  endtask

  // sleep, then quiet/refresh pairs, then wake and one data cycle
  task automatic episode(int ts, int tq, int tr, int nref, int tw);
    drive(1, C_SLP, ts);
    drive(0, C_IDLE, tq);
    expect_iv(0, ts);
    for (int r = 0; r < nref; r++) begin
      drive(1, C_SLP, tr);
      expect_iv(1, tq);
      drive(0, C_IDLE, tq);
      expect_iv(2, tr);
    end
    drive(1, C_IDLE, tw);
    expect_iv(1, tq);
    drive(1, C_DAT, 1);
    expect_iv(3, tw);
    drive(1, C_IDLE, 4);
  endtask

  initial begin
    #(10 * 200000);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int seed;
    int prev;
    seed = int'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    for (int k = 0; k < 4; k++) begin
      check(len_out(k) == 0, "R1", "length after reset", len_out(k), 0);
      check(viol_out(k) == 0, "R1", "violations after reset", viol_out(k), 0);
    end
    check((iv_pass | iv_fail) == 4'b0, "R1", "verdicts after reset", int'(iv_pass | iv_fail), 0);

    // R2 R3 R4 R5 R6: window limits hit exactly
    episode(TS_LO, TQ_LO, TR_LO, 1, TW_MIN);
    compare_events("R6");
    episode(TS_LO + 1, TQ_LO + 1, TR_LO + 1, 1, TW_MIN + 1);
    compare_events("R6");
    episode(TS_HI, TQ_HI, TR_HI, 2, TW_MIN + 8);
    compare_events("R6");
    episode(TS_HI - 1, TQ_HI - 1, TR_HI - 1, 1, 3);
    compare_events("R2");
    check_viol("R10");

    // R5: refresh turning to idle becomes wake and keeps its count
    drive(1, C_SLP, 25); drive(0, C_IDLE, 70); expect_iv(0, 25);
    drive(1, C_SLP, 5); expect_iv(1, 70);
    drive(1, C_IDLE, 12);
    drive(1, C_DAT, 1); expect_iv(3, 17);
    drive(1, C_IDLE, 4);
    compare_events("R5");

    // R7: data during quiet
    prev = int'(tq_len);
    drive(1, C_SLP, 25); drive(0, C_IDLE, 10); expect_iv(0, 25);
    drive(0, C_DAT, 2); drive(1, C_IDLE, 4);
    compare_events("R7");
    check(int'(tq_len) == prev, "R7", "quiet length after truncation", int'(tq_len), prev);
    // R7: data during refresh
    prev = int'(tr_len);
    drive(1, C_SLP, 25); drive(0, C_IDLE, 70); expect_iv(0, 25);
    drive(1, C_SLP, 10); expect_iv(1, 70);
    drive(1, C_DAT, 2); drive(1, C_IDLE, 4);
    compare_events("R7");
    check(int'(tr_len) == prev, "R7", "refresh length after truncation", int'(tr_len), prev);
    // R7: data on the same cycle as the closing edge of quiet
    drive(1, C_SLP, 25); drive(0, C_IDLE, 70); expect_iv(0, 25);
    drive(1, C_DAT, 2); drive(1, C_IDLE, 4);
    compare_events("R7");
    check_viol("R7");

    // R8: sleep abandoned before silence
    drive(1, C_SLP, 10); drive(1, C_IDLE, 3); drive(0, C_IDLE, 5); drive(1, C_IDLE, 3);
    compare_events("R8");
    episode(25, 70, 25, 1, 20);
    compare_events("R8");

    // R12: signal lost during wake
    prev = int'(tw_len);
    drive(1, C_SLP, 25); drive(0, C_IDLE, 70); expect_iv(0, 25);
    drive(1, C_IDLE, 5); expect_iv(1, 70);
    drive(0, C_IDLE, 5); drive(1, C_DAT, 2); drive(1, C_IDLE, 4);
    compare_events("R12");
    check(int'(tw_len) == prev, "R12", "wake length after loss", int'(tw_len), prev);

    // R9: quiet length saturates
    episode(25, 1100, 25, 0, 20);
    compare_events("R9");
    check(int'(tq_len) == LEN_TOP, "R9", "saturated quiet length", int'(tq_len), LEN_TOP);

    // random episodes with fixed seed
    for (int e = 0; e < 30; e++) begin
      episode(rl(TS_LO, TS_HI), rl(TQ_LO, TQ_HI), rl(TR_LO, TR_HI),
              int'($urandom % 3), rl(TW_MIN, TW_MIN + 4));
      compare_events("R6");
    end
    check_viol("R10");

    // R10: violation counter saturation
    for (int e = 0; e < VIO_TOP + 2; e++) episode(25, 70, 25, 0, 5);
    compare_events("R10");
    check_viol("R10");
    check(int'(tw_viol) == VIO_TOP, "R10", "saturated wake violations", int'(tw_viol), VIO_TOP);

    // R11: clear held through failing intervals
    @(negedge clk);
    viol_clr = 1'b1;
    clr_hold = 1'b1;
    for (int k = 0; k < 4; k++) exp_viol[k] = 0;
    episode(TS_LO, TQ_HI, TR_LO, 1, 4);
    compare_events("R11");
    check_viol("R11");
    @(negedge clk);
    viol_clr = 1'b0;
    clr_hold = 1'b0;
    episode(25, 70, 25, 0, 4);
    compare_events("R11");
    check_viol("R11");
    check(int'(tw_viol) == 1, "R11", "wake violations after clear", int'(tw_viol), 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule